// File: doc/BRIEF.md
# SPI Serial-Memory Slave Command Front End

This block is the serial front end of a byte-wide nonvolatile memory. It oversamples the four host pins (serial clock, active-low select, serial input, active-low pause) in a faster system clock and runs the command protocol. Each transaction opens with a falling select edge and an 8-bit instruction. The block decodes six instructions: set and clear of the write-enable latch, status read, status write, array read and array write. Array commands are followed by a 16-bit address. A read then streams bytes out of a synchronous memory port. A write passes each complete data byte downstream with its address.

The block does not decide on protection, program timing or storage. It issues single-cycle request pulses to a status/protection unit and to the memory, and it takes a `busy` level back. While `busy` is high it accepts only the status-read instruction. A pause input freezes the bit position without losing it. The serial output is released (enable low) whenever nothing is being transmitted.

Top module: `spi_mem_front`

## Requirements
- R1: An instruction is taken from the first 8 bits after the select falls, MSB first. Upper nibble 0000 and low bits 110 give one `wel_set` pulse; low bits 100 give one `wel_clr` pulse. Bit 3 is ignored for all six instructions.
- R2: Any other instruction byte (upper nibble not 0000, or low bits 000 or 111) locks the transaction. No pulse is issued and `so_en` stays low until the select falls again. The next transaction works normally.
- R3: While the select is high, `so_en` is low and the serial input has no effect. A transaction cut short mid-byte issues no request. Each rising select edge gives one `txn_end` pulse.
- R4: The serial input is sampled on the rising serial-clock edge. `so` changes only after a falling edge. Both clock-idle-low and clock-idle-high hosts are served.
- R5: Instruction 0000_x011 takes a 16-bit address, keeps only the low AW bits (AW = 14, or 15 with `BIG_ARRAY`) and streams data MSB first. The address increments after each byte and wraps from 2^AW-1 to 0.
- R6: Instruction 0000_x010 takes a 16-bit address. Each complete data byte gives one `mem_wr` pulse with `mem_addr` and `wr_data`. Only the low PAGE_W (6) address bits increment, wrapping inside the page.
- R7: Instruction 0000_x101 streams `sr_rdata` out repeatedly, one byte per 8 clocks, for as long as the select stays low.
- R8: Instruction 0000_x001 sends the first following byte as one `sr_wr` pulse on `wr_data`. Later bytes in the same transaction are ignored.
- R9: `hold_n` is sampled only while the serial clock is low. When low, it freezes bit position and `so`, forces `so_en` low and ignores clock edges and serial input. When high again, the transaction resumes where it stopped.
- R10: While `busy` is high at the end of the instruction byte, every instruction except status read is treated as invalid (R2).
- R11: After reset, `so_en`, `mem_rd`, `mem_wr`, `sr_wr`, `wel_set`, `wel_clr` and `txn_end` are low.
- R12: A read request is a one-cycle `mem_rd` pulse together with its `mem_addr`. `mem_rdata` must be valid on the following clock. One request is issued at address completion and one after each streamed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data from the host |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data to the host |
| so_en | output | 1 | Output enable for `so`; low means high impedance |
| busy | input | 1 | Downstream program cycle in progress |
| sr_rdata | input | 8 | Current status byte to transmit |
| mem_rdata | input | 8 | Memory read data, valid one clock after `mem_rd` |
| mem_addr | output | AW | Memory address for read or write requests |
| mem_rd | output | 1 | Memory read request pulse |
| mem_wr | output | 1 | Memory write request pulse |
| wr_data | output | 8 | Data byte for `mem_wr` or `sr_wr` |
| sr_wr | output | 1 | Status write request pulse |
| wel_set | output | 1 | Set write-enable latch pulse |
| wel_clr | output | 1 | Clear write-enable latch pulse |
| txn_end | output | 1 | Pulse after the select returns high |

## Verification
The hardest state to reach is a pause that lands in the middle of a byte. The serial clock keeps toggling and the serial input keeps changing during it, and the same bit has to be resumed afterwards. The stimulus drops `hold_n` while the clock is low, in an address byte and again in a data byte. It then clocks several full cycles with the input inverted and releases the pause while the clock is low. The bench checks that the streamed data still matches the addressed bytes and that the output stayed released during the pause. The busy lockout is reached by raising `busy` from the bench around complete transactions, and the address wrap by starting a read two bytes below the top of the array with the unused upper address bits set.

// File: rtl/spi_fe_pkg.sv
// Package: shared state and instruction types for the serial memory front end.
// Assumes an 8-bit instruction with a 4-bit zero prefix and a don't-care bit 3.
package spi_fe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_RDAT,
        ST_WDAT,
        ST_SRRD,
        ST_SRWR,
        ST_LOCK
    } fe_state_t;

    typedef enum logic [2:0] {
        OPK_NONE,
        OPK_WSET,
        OPK_WCLR,
        OPK_SRRD,
        OPK_SRWR,
        OPK_ARD,
        OPK_AWR
    } op_kind_t;

    // Classify an instruction byte; bit 3 is never looked at.
    function automatic op_kind_t decode_op(input logic [7:0] b);
        op_kind_t k;
        k = OPK_NONE;
        if (b[7:4] == 4'h0) begin
            case (b[2:0])
                3'b110:  k = OPK_WSET;
                3'b100:  k = OPK_WCLR;
                3'b101:  k = OPK_SRRD;
                3'b001:  k = OPK_SRWR;
                3'b011:  k = OPK_ARD;
                3'b010:  k = OPK_AWR;
                default: k = OPK_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
// Module: multi-stage synchronizer for asynchronous host pins.
// Assumes each pin is held for longer than STAGES+1 system clocks.
// Each pin has its own reset level so that idle pins do not create false edges.
module spi_pin_sync #(
    parameter int          N       = 4,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    for (genvar p = 0; p < N; p++) begin : g_pin
        logic [STAGES-1:0] chain;

        // Shift the raw pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[p]}};
            else        chain <= {chain[STAGES-2:0], din[p]};
        end

        assign dout[p] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_cmd_ctl.sv
// Module: instruction decode, address gathering and request generation.
// Assumes synchronized pin levels and one-cycle edge events from the top.
// Edges are ignored while paused; bit position lives in bitcnt.
module spi_cmd_ctl
    import spi_fe_pkg::*;
#(
    parameter int AW     = 14,
    parameter int PAGE_W = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_on,
    input  logic          cs_fall,
    input  logic          cs_rise,
    input  logic          sck_lvl,
    input  logic          sck_rise,
    input  logic          si_lvl,
    input  logic          holdn_lvl,
    input  logic          busy,
    output fe_state_t     state,
    output logic [2:0]    bitcnt,
    output logic          hold_act,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    wr_data,
    output logic          sr_wr,
    output logic          wel_set,
    output logic          wel_clr,
    output logic          txn_end
);

    localparam int HI_W = AW - 8;
    localparam logic [AW-1:0]     ONE_A = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [PAGE_W-1:0] ONE_P = {{(PAGE_W-1){1'b0}}, 1'b1};

    logic [6:0]    shreg;
    logic [AW-1:0] addr_q;
    logic          addr_ph;
    logic          is_wr;
    logic [7:0]    byte_in;
    logic          byte_end;
    logic          shift_ok;
    op_kind_t      kind;
    logic [AW-1:0] addr_full;
    logic [AW-1:0] rd_next;
    logic [AW-1:0] pg_next;

    // Derive the byte being completed, its classification and next addresses.
    always_comb begin
        byte_in   = {shreg, si_lvl};
        byte_end  = (bitcnt == 3'd7);
        kind      = decode_op(byte_in);
        if (busy && kind != OPK_SRRD) kind = OPK_NONE;
        addr_full = {addr_q[AW-1:8], byte_in};
        rd_next   = addr_q + ONE_A;
        pg_next   = {addr_q[AW-1:PAGE_W], addr_q[PAGE_W-1:0] + ONE_P};
        shift_ok  = cs_on && sck_rise && !hold_act && !cs_fall &&
                    (state != ST_IDLE) && (state != ST_LOCK);
    end

    // Pause flag: follows hold_n only while the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_act <= 1'b0;
        else if (!cs_on)   hold_act <= 1'b0;
        else if (!sck_lvl) hold_act <= ~holdn_lvl;
    end

    // Main sequencer: shift, count bits and act on each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= 3'd0;
            shreg    <= 7'd0;
            addr_q   <= '0;
            addr_ph  <= 1'b0;
            is_wr    <= 1'b0;
            mem_addr <= '0;
            mem_rd   <= 1'b0;
            mem_wr   <= 1'b0;
            wr_data  <= 8'd0;
            sr_wr    <= 1'b0;
            wel_set  <= 1'b0;
            wel_clr  <= 1'b0;
            txn_end  <= 1'b0;
        end else begin
            mem_rd  <= 1'b0;
            mem_wr  <= 1'b0;
            sr_wr   <= 1'b0;
            wel_set <= 1'b0;
            wel_clr <= 1'b0;
            txn_end <= cs_rise;
            if (cs_fall) begin
                state   <= ST_OPC;
                bitcnt  <= 3'd0;
                addr_ph <= 1'b0;
            end else if (!cs_on) begin
                state <= ST_IDLE;
            end else if (shift_ok) begin
                shreg  <= byte_in[6:0];
                bitcnt <= bitcnt + 3'd1;
                if (byte_end) begin
                    case (state)
                        ST_OPC: begin
                            case (kind)
                                OPK_WSET: begin wel_set <= 1'b1; state <= ST_LOCK; end
                                OPK_WCLR: begin wel_clr <= 1'b1; state <= ST_LOCK; end
                                OPK_SRRD: state <= ST_SRRD;
                                OPK_SRWR: state <= ST_SRWR;
                                OPK_ARD:  begin is_wr <= 1'b0; state <= ST_ADDR; end
                                OPK_AWR:  begin is_wr <= 1'b1; state <= ST_ADDR; end
                                default:  state <= ST_LOCK;
                            endcase
                        end
                        ST_ADDR: begin
                            if (!addr_ph) begin
                                addr_q[AW-1:8] <= byte_in[HI_W-1:0];
                                addr_ph        <= 1'b1;
                            end else begin
                                addr_q   <= addr_full;
                                mem_addr <= addr_full;
                                if (is_wr) begin
                                    state <= ST_WDAT;
                                end else begin
                                    state  <= ST_RDAT;
                                    mem_rd <= 1'b1;
                                end
                            end
                        end
                        ST_RDAT: begin
                            addr_q   <= rd_next;
                            mem_addr <= rd_next;
                            mem_rd   <= 1'b1;
                        end
                        ST_WDAT: begin
                            mem_wr   <= 1'b1;
                            wr_data  <= byte_in;
                            mem_addr <= addr_q;
                            addr_q   <= pg_next;
                        end
                        ST_SRWR: begin
                            sr_wr   <= 1'b1;
                            wr_data <= byte_in;
                            state   <= ST_LOCK;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/spi_so_drv.sv
// Module: serial output shifter.
// Assumes the byte source is valid by the first falling edge after a byte
// boundary (bitcnt == 0). It loads there and then walks the byte MSB first.
module spi_so_drv (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_on,
    input  logic       tx_active,
    input  logic       fall_evt,
    input  logic       hold_act,
    input  logic [2:0] bitcnt,
    input  logic [7:0] din,
    output logic       so,
    output logic       so_en
);

    logic [7:0] cur;
    logic       so_q;
    logic       drv;

    // Update the output bit on unpaused falling edges of an active transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= 8'd0;
            so_q <= 1'b0;
            drv  <= 1'b0;
        end else if (!cs_on || !tx_active) begin
            drv <= 1'b0;
        end else if (fall_evt && !hold_act) begin
            drv <= 1'b1;
            if (bitcnt == 3'd0) begin
                cur  <= din;
                so_q <= din[7];
            end else begin
                so_q <= cur[~bitcnt];
            end
        end
    end

    assign so    = so_q;
    assign so_en = drv & ~hold_act & cs_on;

endmodule

// File: rtl/spi_mem_front.sv
// Module: top of the serial memory command front end.
// Assumes clk is at least 8x the serial clock rate, so that each serial clock
// phase spans four or more system clocks after synchronization.
module spi_mem_front
    import spi_fe_pkg::*;
#(
    parameter bit BIG_ARRAY   = 1'b0,
    parameter int PAGE_W      = 6,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = BIG_ARRAY ? 15 : 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck,
    input  logic          cs_n,
    input  logic          si,
    input  logic          hold_n,
    output logic          so,
    output logic          so_en,
    input  logic          busy,
    input  logic [7:0]    sr_rdata,
    input  logic [7:0]    mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [7:0]    wr_data,
    output logic          sr_wr,
    output logic          wel_set,
    output logic          wel_clr,
    output logic          txn_end
);

    logic [3:0] pin_s;
    logic       sck_s, csn_s, si_s, holdn_s;
    logic       sck_d, csn_d;
    logic       sck_rise, sck_fall, cs_fall, cs_rise;
    fe_state_t  state;
    logic [2:0] bitcnt;
    logic       hold_act;
    logic       tx_active;
    logic [7:0] tx_src;

    spi_pin_sync #(
        .N       (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({hold_n, si, cs_n, sck}),
        .dout  (pin_s)
    );

    assign sck_s   = pin_s[0];
    assign csn_s   = pin_s[1];
    assign si_s    = pin_s[2];
    assign holdn_s = pin_s[3];

    // Delay the clock and select levels by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            csn_d <= 1'b1;
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_fall  = ~csn_s & csn_d;
    assign cs_rise  = csn_s & ~csn_d;

    spi_cmd_ctl #(
        .AW     (AW),
        .PAGE_W (PAGE_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_on     (~csn_s),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sck_lvl   (sck_s),
        .sck_rise  (sck_rise),
        .si_lvl    (si_s),
        .holdn_lvl (holdn_s),
        .busy      (busy),
        .state     (state),
        .bitcnt    (bitcnt),
        .hold_act  (hold_act),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .wr_data   (wr_data),
        .sr_wr     (sr_wr),
        .wel_set   (wel_set),
        .wel_clr   (wel_clr),
        .txn_end   (txn_end)
    );

    // Pick the byte source for whichever transmit state is active.
    always_comb begin
        tx_active = (state == ST_RDAT) || (state == ST_SRRD);
        tx_src    = (state == ST_SRRD) ? sr_rdata : mem_rdata;
    end

    spi_so_drv u_so (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_on     (~csn_s),
        .tx_active (tx_active),
        .fall_evt  (sck_fall),
        .hold_act  (hold_act),
        .bitcnt    (bitcnt),
        .din       (tx_src),
        .so        (so),
        .so_en     (so_en)
    );

endmodule

// File: rtl/spi_mem_front_chk.sv
// Module: property checker bound into the front end top.
// Assumes it observes the top's ports and its internal pause and edge signals.
module spi_mem_front_chk (
    input logic clk,
    input logic rst_n,
    input logic so,
    input logic so_en,
    input logic hold_act,
    input logic sck_fall,
    input logic busy,
    input logic wel_set,
    input logic wel_clr,
    input logic sr_wr,
    input logic mem_wr,
    input logic mem_rd,
    input logic txn_end
);

    // At most one request kind per cycle.
    assert_one_request_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wel_set, wel_clr, sr_wr, mem_wr}));

    // The output is released once the select has returned high.
    assert_released_after_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txn_end |-> !so_en);

    // A driven output bit changes only after a falling serial clock edge.
    assert_so_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (so_en && $past(so_en) && (so != $past(so))) |-> $past(sck_fall));

    // The output bit stays frozen through a pause.
    assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_act && $past(hold_act)) |-> $stable(so));

    // No write-enable set is granted while busy.
    assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wel_set |-> !$past(busy));

    // A read request is a single-cycle pulse.
    assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

endmodule

bind spi_mem_front spi_mem_front_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .so       (so),
    .so_en    (so_en),
    .hold_act (hold_act),
    .sck_fall (sck_fall),
    .busy     (busy),
    .wel_set  (wel_set),
    .wel_clr  (wel_clr),
    .sr_wr    (sr_wr),
    .mem_wr   (mem_wr),
    .mem_rd   (mem_rd),
    .txn_end  (txn_end)
);

// File: tb/sim_spi_mem_front.sv
module sim_spi_mem_front;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        hold_n = 1'b1;
    logic        busy = 1'b0;
    logic [7:0]  sr_rdata = 8'h00;
    logic [7:0]  mem_rdata = 8'h00;
    logic        so, so_en;
    logic [13:0] mem_addr;
    logic        mem_rd, mem_wr, sr_wr, wel_set, wel_clr, txn_end;
    logic [7:0]  wr_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit mode3 = 1'b0;

    int cnt_wset = 0, cnt_wclr = 0, cnt_srwr = 0, cnt_rd = 0, cnt_wr = 0;
    int cnt_txe = 0, cnt_en = 0;
    logic [7:0]  last_sr = 8'h00;
    logic [13:0] wlog_a [0:15];
    logic [7:0]  wlog_d [0:15];

    always #2 clk = ~clk;

    spi_mem_front u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_en(so_en), .busy(busy), .sr_rdata(sr_rdata), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .wr_data(wr_data),
        .sr_wr(sr_wr), .wel_set(wel_set), .wel_clr(wel_clr), .txn_end(txn_end)
    );

    function automatic logic [7:0] fexp(input logic [13:0] a);
        return (a[7:0] * 8'd3) ^ {2'b00, a[13:8]};
    endfunction

    // Memory model with one clock of read latency, and request monitors.
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= fexp(mem_addr);
        if (wel_set) cnt_wset <= cnt_wset + 1;
        if (wel_clr) cnt_wclr <= cnt_wclr + 1;
        if (sr_wr) begin cnt_srwr <= cnt_srwr + 1; last_sr <= wr_data; end
        if (mem_rd) cnt_rd <= cnt_rd + 1;
        if (mem_wr) begin
            wlog_a[cnt_wr[3:0]] <= mem_addr;
            wlog_d[cnt_wr[3:0]] <= wr_data;
            cnt_wr <= cnt_wr + 1;
        end
        if (txn_end) cnt_txe <= cnt_txe + 1;
        if (so_en) cnt_en <= cnt_en + 1;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cs_low();
        sck = mode3;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(8);
    endtask

    task automatic cs_high();
        sck = mode3;
        wait_clk(8);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    int hold_en = 0;

    // Shift nbits of tx (MSB first); pause before sampling bit k == hold_at.
    task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at,
                        output logic [7:0] rx);
        rx = 8'h00;
        for (int k = 0; k < nbits; k++) begin
            sck = 1'b0;
            si  = tx[7-k];
            wait_clk(8);
            if (k == hold_at) begin
                hold_n = 1'b0;
                wait_clk(8);
                for (int t = 0; t < 3; t++) begin
                    si  = ~tx[7-k];
                    sck = 1'b1;
                    wait_clk(8);
                    if (so_en) hold_en++;
                    sck = 1'b0;
                    wait_clk(8);
                    if (so_en) hold_en++;
                end
                si = tx[7-k];
                hold_n = 1'b1;
                wait_clk(8);
            end
            rx[7-k] = so;
            sck = 1'b1;
            wait_clk(8);
        end
    endtask

    task automatic byte8(input logic [7:0] tx, output logic [7:0] rx);
        xfer(tx, 8, -1, rx);
    endtask

    // Opcode vectors: {opcode, expect clear, expect set}.
    localparam logic [9:0] VEC [0:7] = '{
        {8'h06, 2'b01}, {8'h0E, 2'b01}, {8'h04, 2'b10}, {8'h0C, 2'b10},
        {8'h16, 2'b00}, {8'h86, 2'b00}, {8'h07, 2'b00}, {8'h00, 2'b00}
    };

    initial begin
        logic [7:0] rx;
        int s_set, s_clr, s_txe, s_en, s_rd, s_wr, s_sr;
        wait_clk(5);
        check("R11 so_en after reset", so_en, 0);
        check("R11 pulses after reset", {mem_rd, mem_wr, sr_wr, wel_set, wel_clr, txn_end}, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R1 / R2 vector walk
        foreach (VEC[i]) begin
            s_set = cnt_wset; s_clr = cnt_wclr; s_txe = cnt_txe; s_en = cnt_en;
            cs_low();
            byte8(VEC[i][9:2], rx);
            byte8(8'h55, rx);
            cs_high();
            check($sformatf("R1 set pulses op %0h", VEC[i][9:2]), cnt_wset - s_set, {31'd0, VEC[i][0]});
            check($sformatf("R2 clr pulses op %0h", VEC[i][9:2]), cnt_wclr - s_clr, {31'd0, VEC[i][1]});
            check("R3 txn_end count", cnt_txe - s_txe, 1);
            check("R2 so_en stays low", cnt_en - s_en, 0);
        end

        // R5 / R12: read across the top of the array, upper address bits set, bit3 set
        s_rd = cnt_rd;
        cs_low();
        byte8(8'h0B, rx);
        byte8(8'hFF, rx);
        byte8(8'hFE, rx);
        byte8(8'h00, rx); check("R5 read byte 3FFE", rx, fexp(14'h3FFE));
        byte8(8'h00, rx); check("R5 read byte 3FFF", rx, fexp(14'h3FFF));
        byte8(8'h00, rx); check("R5 wrap to 0000", rx, fexp(14'h0000));
        cs_high();
        check("R12 read request count", cnt_rd - s_rd, 4);

        // R6: page write wrapping inside a 64-byte page
        s_wr = cnt_wr;
        cs_low(); byte8(8'h06, rx); cs_high();
        cs_low();
        byte8(8'h02, rx); byte8(8'h01, rx); byte8(8'h3E, rx);
        byte8(8'h11, rx); byte8(8'h22, rx); byte8(8'h33, rx);
        xfer(8'hF0, 4, -1, rx);
        cs_high();
        check("R6 write count", cnt_wr - s_wr, 3);
        check("R6 addr 0", wlog_a[s_wr[3:0]], 14'h013E);
        check("R6 addr 1", wlog_a[s_wr[3:0] + 4'd1], 14'h013F);
        check("R6 page wrap addr", wlog_a[s_wr[3:0] + 4'd2], 14'h0100);
        check("R6 data", {wlog_d[s_wr[3:0]], wlog_d[s_wr[3:0] + 4'd1], wlog_d[s_wr[3:0] + 4'd2]}, 24'h112233);

        // R8: status write takes only the first byte
        s_sr = cnt_srwr;
        cs_low(); byte8(8'h01, rx); byte8(8'h5A, rx); byte8(8'h77, rx); cs_high();
        check("R8 status write count", cnt_srwr - s_sr, 1);
        check("R8 status write data", last_sr, 8'h5A);

        // R7: status read repeats
        sr_rdata = 8'hC3;
        cs_low(); byte8(8'h05, rx);
        byte8(8'h00, rx); check("R7 status byte 1", rx, 8'hC3);
        byte8(8'h00, rx); check("R7 status byte 2", rx, 8'hC3);
        cs_high();

        // R2: invalid opcode locks until the next select fall
        s_set = cnt_wset; s_en = cnt_en; s_sr = cnt_srwr;
        cs_low(); byte8(8'hA6, rx); byte8(8'h06, rx); byte8(8'h05, rx); byte8(8'h01, rx); cs_high();
        check("R2 locked no requests", (cnt_wset - s_set) + (cnt_srwr - s_sr), 0);
        check("R2 locked so_en low", cnt_en - s_en, 0);
        cs_low(); byte8(8'h06, rx); cs_high();
        check("R2 next transaction works", cnt_wset - s_set, 1);

        // R10: busy blocks all but status read
        busy = 1'b1;
        s_set = cnt_wset; s_rd = cnt_rd; s_en = cnt_en;
        cs_low(); byte8(8'h06, rx); cs_high();
        cs_low(); byte8(8'h03, rx); byte8(8'h00, rx); byte8(8'h10, rx); byte8(8'h00, rx); cs_high();
        check("R10 busy set blocked", cnt_wset - s_set, 0);
        check("R10 busy read blocked", cnt_rd - s_rd, 0);
        check("R10 busy no output", cnt_en - s_en, 0);
        sr_rdata = 8'hFF;
        cs_low(); byte8(8'h05, rx); byte8(8'h00, rx); cs_high();
        check("R10 status read while busy", rx, 8'hFF);
        busy = 1'b0;

        // R9: pause in an address byte and in a data byte
        hold_en = 0;
        cs_low();
        byte8(8'h03, rx); byte8(8'h00, rx);
        xfer(8'h40, 8, 4, rx);
        xfer(8'h00, 8, 2, rx); check("R9 data after pause", rx, fexp(14'h0040));
        byte8(8'h00, rx);      check("R9 next byte after pause", rx, fexp(14'h0041));
        cs_high();
        check("R9 so_en low during pause", hold_en, 0);

        // R3: select cut mid-byte
        s_set = cnt_wset; s_txe = cnt_txe;
        cs_low(); xfer(8'h06, 4, -1, rx); cs_high();
        check("R3 partial byte no request", cnt_wset - s_set, 0);
        check("R3 txn_end on cut", cnt_txe - s_txe, 1);
        check("R3 so_en low when deselected", so_en, 0);

        // R4: clock-idle-high host
        mode3 = 1'b1;
        cs_low();
        byte8(8'h03, rx); byte8(8'h12, rx); byte8(8'h34, rx);
        byte8(8'h00, rx); check("R4 idle-high read 1", rx, fexp(14'h1234));
        byte8(8'h00, rx); check("R4 idle-high read 2", rx, fexp(14'h1235));
        cs_high();
        mode3 = 1'b0;
        sck = 1'b0;
        wait_clk(10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
            $finish;
        end
    end

endmodule